// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Controller

This block sits between a processor core and an external memory bus whose low 16 lines carry both address and data. The core hands it one request at a time: a 7-bit segment number, a 16-bit offset, a direction, a byte/word flag and, for writes, a data word. The controller then runs two bus cycles on the shared lines. In the first cycle it drives the offset and raises an address strobe so that outside logic can latch the address. In the second cycle it either drives the write word or releases the lines and samples the word that the memory returns.

The segment lines are separate outputs and carry the segment number through both phases. The direction and size flags are held steady for the whole access. The shared lines are presented as an output word, an output enable and an input word, so that the pad ring can build the bidirectional pins. The core sees a ready level, a one-cycle completion pulse and the read word.

Top module: `mux_bus_ctrl`

## Requirements
- R1: After reset the address strobe, the data strobe, the shared-line output enable and the completion pulse are all low, `req_ready` is high and `rd_data` is zero.
- R2: In the cycle after a request is accepted (the address phase), `bus_as` is 1, `bus_ds` is 0, `bus_ad_oe` is 1, `bus_ad_o` equals the request offset and `bus_seg` equals the request segment.
- R3: The cycle after the address phase is the data phase: `bus_ds` is 1 and `bus_as` is 0. For a write, `bus_ad_oe` is 1 and `bus_ad_o` equals the write word.
- R4: For a read, `bus_ad_oe` is 0 during the data phase, and the value on `bus_ad_i` at the end of that phase appears on `rd_data` in the next cycle.
- R5: `done` is high for exactly one cycle, the cycle right after the data phase, so a request accepted at one clock edge completes with `done` high after the third edge.
- R6: `bus_wr` (1 = write, 0 = read), `bus_byte` (1 = byte, 0 = word) and `bus_seg` hold the request's values through both phases. Outside an access, all three are 0.
- R7: A request raised while `req_ready` is low is ignored. The running access keeps its own address and data, and no further access starts from it.
- R8: `req_ready` is high exactly when no access is running, including the cycle in which `done` is high. A request in that cycle begins its address phase in the following cycle.
- R9: `rd_data` changes only when a read completes, and keeps its value through write accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | One-cycle request pulse from the core |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_byte | input | 1 | 1 = byte access, 0 = word access |
| req_seg | input | 7 | Segment number |
| req_off | input | 16 | Offset within the segment |
| req_wdata | input | 16 | Write word |
| req_ready | output | 1 | Controller idle, request will be accepted |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Word captured by the last read |
| bus_seg | output | 7 | Segment lines, not shared |
| bus_ad_o | output | 16 | Shared lines, outgoing value |
| bus_ad_oe | output | 1 | Shared lines output enable |
| bus_ad_i | input | 16 | Shared lines, incoming value |
| bus_as | output | 1 | Address strobe, high only in the address phase |
| bus_ds | output | 1 | Data strobe, high only in the data phase |
| bus_wr | output | 1 | Direction flag held for the access |
| bus_byte | output | 1 | Size flag held for the access |

## Verification
The completion pulse of one access and the acceptance of the next request can fall in the same cycle, because the controller is ready again while `done` is high. The bench provokes this by chaining accesses from its vector table, raising each new request in the cycle where the previous one reports done. It then judges that the old read word is already on `rd_data`, that `done` falls in the next cycle, and that this next cycle is the new address phase carrying the new offset. A second case raises requests during both busy phases. The bench confirms that the running access keeps its offset and data and that no extra address strobe follows.

// File: rtl/mbus_pkg.sv
package mbus_pkg;

    parameter int SEG_W  = 7;
    parameter int DATA_W = 16;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ADDR = 2'd1,
        PH_DATA = 2'd2
    } phase_e;

    typedef struct packed {
        logic              wr;
        logic              sz_byte;
        logic [SEG_W-1:0]  seg;
        logic [DATA_W-1:0] off;
        logic [DATA_W-1:0] wdata;
    } bus_req_t;

    function automatic logic phase_busy(input phase_e ph);
        return ph != PH_IDLE;
    endfunction

endpackage

// File: rtl/mbus_req_latch.sv
module mbus_req_latch
    import mbus_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     accept,
    input  bus_req_t req_in,
    output bus_req_t req_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= '0;
        end else if (accept) begin
            req_q <= req_in;
        end
    end

endmodule

// File: rtl/mbus_phase_seq.sv
module mbus_phase_seq
    import mbus_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   req_valid,
    output logic   ready,
    output logic   accept,
    output phase_e phase,
    output logic   done
);

    phase_e phase_nx;

    always_comb begin
        ready  = !phase_busy(phase);
        accept = ready && req_valid;
        case (phase)
            PH_IDLE: phase_nx = accept ? PH_ADDR : PH_IDLE;
            PH_ADDR: phase_nx = PH_DATA;
            PH_DATA: phase_nx = PH_IDLE;
            default: phase_nx = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            done  <= 1'b0;
        end else begin
            phase <= phase_nx;
            done  <= (phase == PH_DATA);
        end
    end

endmodule

// File: rtl/mbus_pad_ctrl.sv
module mbus_pad_ctrl
    import mbus_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  phase_e            phase,
    input  bus_req_t          req_q,
    input  logic [DATA_W-1:0] ad_in,
    output logic [DATA_W-1:0] ad_out,
    output logic              ad_oe,
    output logic [SEG_W-1:0]  seg_out,
    output logic              as_out,
    output logic              ds_out,
    output logic              wr_out,
    output logic              byte_out,
    output logic [DATA_W-1:0] rd_word
);

    logic in_addr;
    logic in_data;
    logic busy;

    always_comb begin
        in_addr  = (phase == PH_ADDR);
        in_data  = (phase == PH_DATA);
        busy     = phase_busy(phase);
        as_out   = in_addr;
        ds_out   = in_data;
        seg_out  = busy ? req_q.seg : '0;
        wr_out   = busy && req_q.wr;
        byte_out = busy && req_q.sz_byte;
        ad_oe    = in_addr || (in_data && req_q.wr);
        if (in_addr) begin
            ad_out = req_q.off;
        end else if (in_data && req_q.wr) begin
            ad_out = req_q.wdata;
        end else begin
            ad_out = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_word <= '0;
        end else if (in_data && !req_q.wr) begin
            rd_word <= ad_in;
        end
    end

endmodule

// File: rtl/mux_bus_ctrl.sv
module mux_bus_ctrl
    import mbus_pkg::*;
#(
    parameter int SW = SEG_W,
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  logic          req_wr,
    input  logic          req_byte,
    input  logic [SW-1:0] req_seg,
    input  logic [DW-1:0] req_off,
    input  logic [DW-1:0] req_wdata,
    output logic          req_ready,
    output logic          done,
    output logic [DW-1:0] rd_data,
    output logic [SW-1:0] bus_seg,
    output logic [DW-1:0] bus_ad_o,
    output logic          bus_ad_oe,
    input  logic [DW-1:0] bus_ad_i,
    output logic          bus_as,
    output logic          bus_ds,
    output logic          bus_wr,
    output logic          bus_byte
);

    bus_req_t req_in;
    bus_req_t req_q;
    phase_e   phase;
    logic     accept;

    always_comb begin
        req_in.wr      = req_wr;
        req_in.sz_byte = req_byte;
        req_in.seg     = req_seg;
        req_in.off     = req_off;
        req_in.wdata   = req_wdata;
    end

    mbus_phase_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .ready     (req_ready),
        .accept    (accept),
        .phase     (phase),
        .done      (done)
    );

    mbus_req_latch u_latch (
        .clk    (clk),
        .rst    (rst),
        .accept (accept),
        .req_in (req_in),
        .req_q  (req_q)
    );

    mbus_pad_ctrl u_pad (
        .clk      (clk),
        .rst      (rst),
        .phase    (phase),
        .req_q    (req_q),
        .ad_in    (bus_ad_i),
        .ad_out   (bus_ad_o),
        .ad_oe    (bus_ad_oe),
        .seg_out  (bus_seg),
        .as_out   (bus_as),
        .ds_out   (bus_ds),
        .wr_out   (bus_wr),
        .byte_out (bus_byte),
        .rd_word  (rd_data)
    );

endmodule

// File: rtl/mbus_ctrl_chk.sv
module mbus_ctrl_chk #(
    parameter int SW = 7,
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          req_valid,
    input logic          req_ready,
    input logic          done,
    input logic [DW-1:0] rd_data,
    input logic [SW-1:0] bus_seg,
    input logic          bus_ad_oe,
    input logic          bus_as,
    input logic          bus_ds,
    input logic          bus_wr,
    input logic          bus_byte
);

    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> (!bus_as && !bus_ds && !bus_ad_oe && !done && req_ready && rd_data == '0));

    assert_accept_addr_R2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> (bus_as && bus_ad_oe));

    assert_addr_then_data_R3: assert property (@(posedge clk) disable iff (rst)
        bus_as |=> (bus_ds && !bus_as));

    assert_strobes_excl_R3: assert property (@(posedge clk) disable iff (rst)
        !(bus_as && bus_ds));

    assert_read_release_R4: assert property (@(posedge clk) disable iff (rst)
        (bus_ds && !bus_wr) |-> !bus_ad_oe);

    assert_done_after_data_R5: assert property (@(posedge clk) disable iff (rst)
        bus_ds |=> (done && !bus_ds));

    assert_done_single_R5: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_flags_stable_R6: assert property (@(posedge clk) disable iff (rst)
        bus_as |=> ($stable(bus_wr) && $stable(bus_byte) && $stable(bus_seg)));

    assert_busy_ignore_R7: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_ready) |=> !bus_as);

    assert_ready_idle_R8: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (!bus_as && !bus_ds));

    assert_rdata_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (bus_ds && bus_wr) |=> $stable(rd_data));

endmodule

bind mux_bus_ctrl mbus_ctrl_chk #(.SW(SW), .DW(DW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .done      (done),
    .rd_data   (rd_data),
    .bus_seg   (bus_seg),
    .bus_ad_oe (bus_ad_oe),
    .bus_as    (bus_as),
    .bus_ds    (bus_ds),
    .bus_wr    (bus_wr),
    .bus_byte  (bus_byte)
);

// File: tb/test_mux_bus_ctrl.sv
module test_mux_bus_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 8;

    // {wr, byte, seg[6:0], off[15:0], wdata[15:0]}
    localparam logic [40:0] VEC [NVEC] = '{
        {1'b0, 1'b0, 7'h00, 16'h0000, 16'h0000},
        {1'b1, 1'b0, 7'h7F, 16'hFFFF, 16'h1234},
        {1'b0, 1'b1, 7'h2A, 16'h8001, 16'h0000},
        {1'b1, 1'b1, 7'h01, 16'h00FE, 16'hABCD},
        {1'b1, 1'b0, 7'h55, 16'h5555, 16'hAAAA},
        {1'b0, 1'b0, 7'h7F, 16'hFFFF, 16'h0000},
        {1'b0, 1'b1, 7'h10, 16'h1357, 16'h0000},
        {1'b1, 1'b0, 7'h3C, 16'hC0DE, 16'h0F0F}
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_wr, req_byte;
    logic [6:0]  req_seg;
    logic [15:0] req_off, req_wdata;
    logic        req_ready, done;
    logic [15:0] rd_data;
    logic [6:0]  bus_seg;
    logic [15:0] bus_ad_o, bus_ad_i;
    logic        bus_ad_oe, bus_as, bus_ds, bus_wr, bus_byte;

    logic [15:0] lat_off;
    logic [6:0]  lat_seg;
    logic [15:0] exp_rd;
    int compared = 0;
    int mismatched = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mux_bus_ctrl i_mux_bus_ctrl (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_wr(req_wr), .req_byte(req_byte),
        .req_seg(req_seg), .req_off(req_off), .req_wdata(req_wdata),
        .req_ready(req_ready), .done(done), .rd_data(rd_data),
        .bus_seg(bus_seg), .bus_ad_o(bus_ad_o), .bus_ad_oe(bus_ad_oe),
        .bus_ad_i(bus_ad_i), .bus_as(bus_as), .bus_ds(bus_ds),
        .bus_wr(bus_wr), .bus_byte(bus_byte)
    );

    function automatic logic [15:0] mem_word(input logic [6:0] s, input logic [15:0] o);
        return o ^ {s, 9'h15A};
    endfunction

    // external address latch and memory responder
    always_ff @(posedge clk) begin
        if (bus_as) begin
            lat_off <= bus_ad_o;
            lat_seg <= bus_seg;
        end
    end
    assign bus_ad_i = (bus_ds && !bus_wr) ? mem_word(lat_seg, lat_off) : 16'h0000;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    // called at a negedge while idle; returns at the negedge of the done cycle
    task automatic do_access(input logic [40:0] v, input logic poke);
        logic wr;
        logic bt;
        logic [6:0] sg;
        logic [15:0] of;
        logic [15:0] wd;
        {wr, bt, sg, of, wd} = v;
        req_valid = 1'b1; req_wr = wr; req_byte = bt;
        req_seg = sg; req_off = of; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R2 addr strobe", {bus_as, bus_ds, bus_ad_oe}, 3'b101);
        chk("R2 addr offset", bus_ad_o, of);
        chk("R2 addr segment", bus_seg, sg);
        chk("R6 flags addr", {bus_wr, bus_byte}, {wr, bt});
        chk("R5 no early done", done, 0);
        chk("R8 busy addr", req_ready, 0);
        if (poke) begin
            req_valid = 1'b1; req_off = ~of; req_seg = ~sg; req_wdata = ~wd; req_wr = ~wr;
        end
        @(negedge clk);
        chk("R3 data strobe", {bus_as, bus_ds}, 2'b01);
        chk("R6 flags data", {bus_wr, bus_byte, bus_seg}, {wr, bt, sg});
        if (wr) begin
            chk("R3 write oe", bus_ad_oe, 1);
            chk("R3 write word", bus_ad_o, wd);
        end else begin
            chk("R4 read release", bus_ad_oe, 0);
        end
        @(negedge clk);
        req_valid = 1'b0;
        if (!wr) exp_rd = mem_word(sg, of);
        chk("R5 done pulse", done, 1);
        chk("R8 ready at done", req_ready, 1);
        chk(wr ? "R9 rdata held" : "R4 read word", rd_data, exp_rd);
        chk("R6 idle flags", {bus_as, bus_ds, bus_ad_oe, bus_wr, bus_byte, bus_seg}, 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        rst = 1'b1; req_valid = 1'b0; req_wr = 1'b0; req_byte = 1'b0;
        req_seg = '0; req_off = '0; req_wdata = '0; exp_rd = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R1 reset outputs", {bus_as, bus_ds, bus_ad_oe, done, req_ready}, 5'b00001);
        chk("R1 reset rdata", rd_data, 0);
        @(negedge clk);

        // table: chained, each new request raised in the previous done cycle (R8)
        for (int i = 0; i < NVEC; i++) begin
            do_access(VEC[i], 1'b0);
        end
        @(negedge clk);
        chk("R5 done falls", done, 0);
        chk("R8 idle after chain", {req_ready, bus_as}, 2'b10);

        // requests while busy are ignored (R7)
        do_access({1'b0, 1'b0, 7'h33, 16'h4242, 16'h0000}, 1'b1);
        @(negedge clk);
        chk("R7 no extra access", {bus_as, bus_ds, done}, 3'b000);
        do_access({1'b1, 1'b0, 7'h0F, 16'h0102, 16'h7E7E}, 1'b1);
        @(negedge clk);
        chk("R7 no extra access wr", {bus_as, bus_ds, done}, 3'b000);
        chk("R9 rdata after write", rd_data, exp_rd);

        // reset in mid access
        req_valid = 1'b1; req_wr = 1'b1; req_off = 16'h9999;
        @(negedge clk);
        req_valid = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R1 reset mid access", {bus_as, bus_ds, bus_ad_oe, done, req_ready}, 5'b00001);
        chk("R1 reset clears rdata", rd_data, 0);
        summary();
    end

endmodule